// File: doc/BRIEF.md
# Muller Handshake Control Chain

This block models the control half of an elastic Muller pipeline on a synchronous clock. It is a chain of C-element stages. Each stage holds one state bit. The left environment drives a request into the chain and gets back an acknowledge. The right environment sees the outgoing request and answers with its own acknowledge. Every C-element is evaluated once per clock edge from the values its neighbours held before that edge. An event therefore moves forward by exactly one stage per cycle, and the ripple is deterministic and easy to observe.

The block also reports how much the chain holds. It does this without a counter and without treating any stage level as meaningful on its own. Only the relation between neighbouring stages matters. A neighbouring pair that disagrees marks an event in flight, and the last stage is compared against the right-side acknowledge. From these comparisons the block drives an empty flag, a full flag and an occupancy count. A parameter picks whether every stage starts at 0 or at 1. The status logic works the same for either start value.

Top module: `muller_ctl`

## Requirements
- R1: During reset, every stage takes the start value chosen by INIT_ONE (0 or 1). With ack_out equal to that value, the first cycle after reset shows empty=1, full=0, occupancy=0, and ack_in and req_out both equal to the start value.
- R2: The first stage is driven onto ack_in. On a clock edge where req_in differs from the second stage, the first stage takes the value of req_in. Otherwise it keeps its value.
- R3: An interior stage k copies stage k-1 on an edge where stage k-1 differs from stage k+1, and holds otherwise. All stages use their pre-edge neighbour values.
- R4: The last stage is driven onto req_out. On an edge where the next-to-last stage differs from ack_out, the last stage copies the next-to-last stage. Otherwise it holds.
- R5: empty is 1 exactly when all stages are equal and req_out equals ack_out. With all stages equal but req_out different from ack_out, the chain holds one entry and empty is 0.
- R6: full is 1 exactly when every stage differs from each of its neighbours (0101 or 1010 for four stages).
- R7: occupancy counts the adjacent pairs whose values differ. The pairs are the STAGES-1 stage pairs plus the pair formed by the last stage and ack_out. Its range is 0 to STAGES.
- R8: In an empty chain, a change on req_in reaches req_out on exactly the STAGES-th clock edge.
- R9: While the chain is full, a change on req_in that does not match the first stage's successor condition is not taken: ack_in keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Evaluation clock; all stages update on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset to the start value |
| req_in | input | 1 | Request from the left environment |
| ack_in | output | 1 | Acknowledge to the left environment (first stage) |
| req_out | output | 1 | Request to the right environment (last stage) |
| ack_out | input | 1 | Acknowledge from the right environment |
| empty | output | 1 | No event in flight |
| full | output | 1 | Stages alternate along the whole chain |
| occupancy | output | clog2(STAGES+1) | Number of disagreeing neighbour pairs |

## Verification
The hardest state to reach from the ports is the alternating, full pattern with a stalled right side. It can only be built by toggling req_in several times while ack_out is held still. Each toggle must wait until the previous event has rippled down to the first bubble. The stimulus table does exactly this, and it then offers a request that must be refused. It then drains the chain through a series of right-side acknowledges. One step of the drain leaves all stages equal while req_out and ack_out still differ, which tells the one-entry case apart from the empty case. A second instance started at the opposite polarity checks that the status does not depend on absolute levels.

// File: rtl/mp_pkg.sv
package mp_pkg;

  // Width needed to hold a count from 0 to n inclusive.
  function automatic int occ_width(input int n);
    return $clog2(n + 1);
  endfunction

  // C-element next state: follow the inputs when they agree, else keep.
  function automatic logic celem_next(input logic a, input logic b, input logic q);
    return (a == b) ? a : q;
  endfunction

  // One neighbour comparison: 1 marks an event in flight between them.
  function automatic logic pair_differs(input logic left, input logic right);
    return left ^ right;
  endfunction

endpackage

// File: rtl/mp_celem.sv
module mp_celem #(
  parameter bit INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a,
  input  logic b,
  output logic q
);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= INIT;
    else        q <= mp_pkg::celem_next(a, b, q);
  end

endmodule

// File: rtl/mp_stage_chain.sv
module mp_stage_chain #(
  parameter int STAGES   = 4,
  parameter bit INIT_ONE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_in,
  input  logic              ack_out,
  output logic [STAGES-1:0] stage_q
);

  localparam int LAST = STAGES - 1;

  // Named neighbour views: what each stage sees on its two sides.
  logic [STAGES-1:0] pred_w;
  logic [STAGES-1:0] succ_w;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign pred_w[k] = req_in;
    end else begin : g_body_pred
      assign pred_w[k] = stage_q[k-1];
    end

    if (k == LAST) begin : g_tail
      assign succ_w[k] = ack_out;
    end else begin : g_body_succ
      assign succ_w[k] = stage_q[k+1];
    end

    mp_celem #(.INIT(INIT_ONE)) u_celem (
      .clk   (clk),
      .rst_n (rst_n),
      .a     (pred_w[k]),
      .b     (~succ_w[k]),
      .q     (stage_q[k])
    );
  end

endmodule

// File: rtl/mp_status.sv
module mp_status #(
  parameter int STAGES = 4,
  localparam int OCC_W = mp_pkg::occ_width(STAGES)
) (
  input  logic [STAGES-1:0] stage_q,
  input  logic              ack_out,
  output logic              empty,
  output logic              full,
  output logic [OCC_W-1:0]  occupancy
);

  localparam int LAST = STAGES - 1;

  // diff_w[k] compares stage k with its right neighbour; the last entry
  // compares the final stage with the right-side acknowledge.
  logic [STAGES-1:0] diff_w;

  for (genvar k = 0; k < STAGES; k++) begin : g_pair
    if (k == LAST) begin : g_edge
      assign diff_w[k] = mp_pkg::pair_differs(stage_q[k], ack_out);
    end else begin : g_inner
      assign diff_w[k] = mp_pkg::pair_differs(stage_q[k], stage_q[k+1]);
    end
  end

  always_comb begin
    occupancy = '0;
    for (int k = 0; k < STAGES; k++) begin
      occupancy = occupancy + OCC_W'(diff_w[k]);
    end
  end

  assign empty = ~|diff_w;
  assign full  = &diff_w[LAST-1:0];

endmodule

// File: rtl/muller_ctl.sv
module muller_ctl #(
  parameter int STAGES   = 4,
  parameter bit INIT_ONE = 1'b0
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  req_in,
  output logic                                  ack_in,
  output logic                                  req_out,
  input  logic                                  ack_out,
  output logic                                  empty,
  output logic                                  full,
  output logic [mp_pkg::occ_width(STAGES)-1:0]  occupancy
);

  logic [STAGES-1:0] stage_q;

  mp_stage_chain #(.STAGES(STAGES), .INIT_ONE(INIT_ONE)) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_in  (req_in),
    .ack_out (ack_out),
    .stage_q (stage_q)
  );

  mp_status #(.STAGES(STAGES)) u_status (
    .stage_q   (stage_q),
    .ack_out   (ack_out),
    .empty     (empty),
    .full      (full),
    .occupancy (occupancy)
  );

  assign ack_in  = stage_q[0];
  assign req_out = stage_q[STAGES-1];

endmodule

// File: rtl/mp_ctl_checker.sv
module mp_ctl_checker #(
  parameter int STAGES = 4,
  localparam int OCC_W = mp_pkg::occ_width(STAGES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_in,
  input logic              ack_out,
  input logic [STAGES-1:0] stage_q,
  input logic              empty,
  input logic              full,
  input logic [OCC_W-1:0]  occupancy
);

  localparam int LAST = STAGES - 1;

  // R2: head stage captures a disagreeing request, else holds
  p_head_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_in != stage_q[1]) |=> (stage_q[0] == $past(req_in)));
  p_head_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_in == stage_q[1]) |=> $stable(stage_q[0]));

  // R3: interior stages copy only across a disagreeing neighbour pair
  for (genvar k = 1; k < LAST; k++) begin : g_mid
    p_mid_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_q[k-1] != stage_q[k+1]) |=> (stage_q[k] == $past(stage_q[k-1])));
    p_mid_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_q[k-1] == stage_q[k+1]) |=> $stable(stage_q[k]));
  end

  // R4: tail stage handshakes with the right-side acknowledge
  p_tail_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q[LAST-1] != ack_out) |=> (stage_q[LAST] == $past(stage_q[LAST-1])));
  p_tail_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q[LAST-1] == ack_out) |=> $stable(stage_q[LAST]));

  // R5: empty implies uniform stages and no count
  p_empty_uniform_r5: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> ((stage_q == {STAGES{stage_q[0]}}) && (occupancy == '0)));

  // R6: full implies every inner pair contributes to the count
  p_full_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (occupancy >= OCC_W'(LAST)));

  // R7: count never exceeds the number of pairs
  p_occ_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= OCC_W'(STAGES));

endmodule

bind muller_ctl mp_ctl_checker #(.STAGES(STAGES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_in    (req_in),
  .ack_out   (ack_out),
  .stage_q   (stage_q),
  .empty     (empty),
  .full      (full),
  .occupancy (occupancy)
);

// File: tb/muller_ctl_tb.sv
`timescale 1ns/1ps
module muller_ctl_tb;

  localparam int STAGES = 4;
  localparam int OW     = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_in = 1'b0, ack_out = 1'b0;
  logic hi_req = 1'b1, hi_ack = 1'b1;
  logic ack_in, req_out, empty, full;
  logic hi_ack_in, hi_req_out, hi_empty, hi_full;
  logic [OW-1:0] occupancy, hi_occ;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  muller_ctl #(.STAGES(STAGES), .INIT_ONE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .ack_in(ack_in),
    .req_out(req_out), .ack_out(ack_out), .empty(empty), .full(full),
    .occupancy(occupancy));

  muller_ctl #(.STAGES(STAGES), .INIT_ONE(1'b1)) u_dut_hi (
    .clk(clk), .rst_n(rst_n), .req_in(hi_req), .ack_in(hi_ack_in),
    .req_out(hi_req_out), .ack_out(hi_ack), .empty(hi_empty), .full(hi_full),
    .occupancy(hi_occ));

  // {req_in, ack_out, ack_in, req_out, empty, full, occupancy[2:0]}
  localparam logic [8:0] VEC [19] = '{
    9'b10_1000_001, // 1000 request enters
    9'b10_1000_001, // 1100
    9'b10_1000_001, // 1110
    9'b10_1100_001, // 1111 one entry, stages uniform
    9'b00_0100_010, // 0111
    9'b00_0100_010, // 0011
    9'b00_0100_010, // 0001
    9'b00_0100_010, // 0001 bubble waits
    9'b10_1100_011, // 1001
    9'b10_1100_011, // 1101
    9'b10_1100_011, // 1101 stalled
    9'b00_0101_100, // 0101 full
    9'b10_0101_100, // 0101 request refused (R9)
    9'b01_0000_011, // 0100 right acknowledges
    9'b00_0000_010, // 0110
    9'b00_0100_010, // 0011
    9'b01_0100_001, // 0001
    9'b01_0000_001, // 0000 but req_out != ack_out
    9'b00_0010_000  // 0000 truly empty
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state, polarity 0
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 occupancy", occupancy, 0);
    chk("R1 ack_in", ack_in, 0);
    chk("R1 req_out", req_out, 0);
    // R1 reset state, polarity 1
    chk("R1 hi empty", hi_empty, 1);
    chk("R1 hi occupancy", hi_occ, 0);
    chk("R1 hi ack_in", hi_ack_in, 1);
    chk("R1 hi req_out", hi_req_out, 1);
    @(negedge clk);
    rst_n  = 1'b1;
    hi_req = 1'b0;
    step();
    // R2 with start value 1: falling request taken by the head stage
    chk("R2 hi ack_in", hi_ack_in, 0);
    chk("R7 hi occupancy", hi_occ, 1);
    chk("R5 hi empty", hi_empty, 0);

    // Table walk: R2 ack_in, R4 req_out, R5 empty, R6 full, R7 occupancy;
    // the stepwise ripple in rows 0-3 and 13-16 exercises R3.
    for (int i = 0; i < 19; i++) begin
      @(negedge clk);
      req_in  = VEC[i][8];
      ack_out = VEC[i][7];
      step();
      chk((i == 12) ? "R9 ack_in held while full" : $sformatf("R2 ack_in row %0d", i),
          ack_in, VEC[i][6]);
      chk($sformatf("R4 req_out row %0d", i), req_out, VEC[i][5]);
      chk($sformatf("R5 empty row %0d", i), empty, VEC[i][4]);
      chk($sformatf("R6 full row %0d", i), full, VEC[i][3]);
      chk($sformatf("R7 occupancy row %0d", i), occupancy, VEC[i][2:0]);
    end

    // R8 / R3: from empty, a request needs exactly STAGES edges to emerge
    @(negedge clk);
    req_in = 1'b1;
    for (int e = 1; e <= STAGES; e++) begin
      step();
      chk($sformatf("R8 req_out after %0d edges", e), req_out, (e == STAGES) ? 1 : 0);
      chk("R3 ack_in stays raised", ack_in, 1);
    end

    // R1: reset from a non-empty state returns to the start value
    chk("R5 one entry not empty", empty, 0);
    @(negedge clk);
    rst_n = 1'b0;
    req_in = 1'b0;
    step();
    chk("R1 reset clears req_out", req_out, 0);
    chk("R1 reset empty", empty, 1);
    chk("R1 reset occupancy", occupancy, 0);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    finish_run();
  end

endmodule